// File: doc/BRIEF.md
# Protected Clock Group Selector

This controller picks which of three clock-plus-sync input groups drives a line card's timing: a master group, a slave group and a standby group. A downstream multiplexer uses the group code to steer an equipment clock and its frame sync together, so the two signals of a group always move as one unit. The controller runs a rising-edge activity monitor on each of the three sampled clock inputs. Each monitor counts cycles of a local reference clock.

A single level-sensitive force pin states which of master and slave is preferred. When the preferred input is unhealthy, the selector falls back through a fixed chain: the other of master and slave, then the standby group if it is enabled, then no input at all. Selection is non-revertive. A recovered input is not taken back until the current one fails or the force pin changes. A mode output reports free-run from reset, locked once a selection has been held for a settling time, and holdover when all inputs have been lost after lock was reached. A one-cycle strobe marks every change of the group code.

Top module: `prot_clk_sel`

## Requirements
- R1: While reset is held and on the first cycles after it, the group code is 2'b11 (no input), the mode is 2'b00 (free-run) and all three alarm bits are 1.
- R2: Alarm bit i (0 master, 1 slave, 2 standby) is set once input i has shown no rising edge for TIMEOUT reference cycles.
- R3: A set alarm clears only after GOOD_EDGES consecutive rising edges, each arriving within TIMEOUT cycles of the one before. A burst of fewer edges leaves it set.
- R4: Force pin 0 prefers master (code 2'b00) and force pin 1 prefers slave (code 2'b01). When the force pin changes and the newly preferred input is healthy, that input is selected.
- R5: When the selected master or slave input raises its alarm, the other of the two is selected if it is healthy.
- R6: A force pin change toward an input whose alarm is set is ignored, and the current selection is kept.
- R7: Selection is non-revertive. Recovery of a preferred input does not change the selection while the current input stays healthy and the force pin is unchanged.
- R8: When master and slave are both alarmed, the standby enable is 1 and the standby input is healthy, the code is 2'b10.
- R9: When no usable input exists, the code is 2'b11. The mode is then 2'b10 (holdover) if the mode has been locked since reset, and 2'b00 otherwise.
- R10: The mode becomes 2'b01 (locked) once an input has been selected continuously for SETTLE cycles after leaving the no-input state. Switches between usable inputs keep it locked.
- R11: Each change of the group code is marked by the switch strobe, high for exactly one cycle in the cycle the new code first appears.
- R12: With the standby enable at 0, the standby group is never selected, and an existing standby selection is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Local reference clock for monitors and control |
| rstN | input | 1 | Active-low synchronous reset |
| clkIn | input | 3 | Sampled clocks: bit 0 master, bit 1 slave, bit 2 standby |
| forcePin | input | 1 | 0 prefers master, 1 prefers slave |
| standbyEn | input | 1 | 1 when the standby group may be used |
| grpSel | output | 2 | 00 master, 01 slave, 10 standby, 11 none |
| opMode | output | 2 | 00 free-run, 01 locked, 10 holdover |
| alarm | output | 3 | Per-input activity failure flags |
| swEvt | output | 1 | One-cycle strobe on each group code change |

## Verification
A monitor whose idle or good-edge counter goes astray shows at the alarm port within about one timeout window, either as an alarm that never clears or one that fires on a running clock. A wrong stored selection or force history shows at the next input failure or force pin change, as a code that reverts or fails to move, together with a strobe count that no longer matches the number of switches. A damaged settle counter or lock history appears at the mode port within SETTLE cycles of a recovery, or at the next total loss of inputs.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [1:0] {
    GS_MASTER  = 2'b00,
    GS_SLAVE   = 2'b01,
    GS_STANDBY = 2'b10,
    GS_NONE    = 2'b11
  } grp_e;

  typedef enum logic [1:0] {
    MD_FREERUN  = 2'b00,
    MD_LOCKED   = 2'b01,
    MD_HOLDOVER = 2'b10
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selValid;  // an input is currently selected
    logic restart;   // leaving the no-input state this cycle
  } ctrl_strb_t;

endpackage

// File: rtl/pcs_actmon.sv
module pcs_actmon #(
  parameter int TIMEOUT    = 16,
  parameter int GOOD_EDGES = 4
) (
  input  logic refClk,
  input  logic rstN,
  input  logic clkRaw,
  output logic failFlag
);
  localparam int IW = $clog2(TIMEOUT + 1);
  localparam int GW = $clog2(GOOD_EDGES + 1);

  logic          sync1, sync2, prevQ;
  logic [IW-1:0] idleCnt;
  logic [GW-1:0] goodCnt;
  logic          rise;

  assign rise = sync2 & ~prevQ;

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      prevQ    <= 1'b0;
      idleCnt  <= '0;
      goodCnt  <= '0;
      failFlag <= 1'b1;
    end else begin
      sync1 <= clkRaw;
      sync2 <= sync1;
      prevQ <= sync2;
      if (rise) begin
        idleCnt <= '0;
        if (failFlag) begin
          if (goodCnt == GW'(GOOD_EDGES - 1)) begin
            failFlag <= 1'b0;
            goodCnt  <= '0;
          end else begin
            goodCnt <= goodCnt + 1'b1;
          end
        end
      end else if (idleCnt == IW'(TIMEOUT)) begin
        failFlag <= 1'b1;
        goodCnt  <= '0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  // alarm clears only on a detected edge
  p_clear_on_edge_r3: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(failFlag) |-> $past(rise));

  // alarm rises only after a full idle window
  p_set_after_idle_r2: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(failFlag) |-> $past(idleCnt) == IW'(TIMEOUT));

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int NUM_IN     = 3,
  parameter int TIMEOUT    = 16,
  parameter int GOOD_EDGES = 4,
  parameter int SETTLE     = 8
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] clkIn,
  input  ctrl_strb_t        strb,
  output logic [NUM_IN-1:0] failVec,
  output logic              settled
);
  localparam int SW = $clog2(SETTLE + 1);

  logic [SW-1:0] settleCnt;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_mon
    pcs_actmon #(.TIMEOUT(TIMEOUT), .GOOD_EDGES(GOOD_EDGES)) mon_i (
      .refClk  (refClk),
      .rstN    (rstN),
      .clkRaw  (clkIn[i]),
      .failFlag(failVec[i])
    );
  end

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strb.restart) begin
      settleCnt <= '0;
    end else if (strb.selValid && settleCnt != SW'(SETTLE)) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  assign settled = (settleCnt == SW'(SETTLE));

  p_settle_bound_r10: assert property (@(posedge refClk) disable iff (!rstN)
    settleCnt <= SW'(SETTLE));

endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic       refClk,
  input  logic       rstN,
  input  logic [2:0] failVec,
  input  logic       forcePin,
  input  logic       standbyEn,
  input  logic       settled,
  output ctrl_strb_t strb,
  output grp_e       selQ,
  output mode_e      modeOut,
  output logic       swEvt
);
  logic [2:0] okVec;
  logic       forceQ, everLocked, forceChg;
  logic       okPref, okAlt, curOk;
  grp_e       prefGrp, altGrp, selNxt;

  assign okVec    = {~failVec[2] & standbyEn, ~failVec[1], ~failVec[0]};
  assign forceChg = forcePin ^ forceQ;
  assign prefGrp  = forcePin ? GS_SLAVE : GS_MASTER;
  assign altGrp   = forcePin ? GS_MASTER : GS_SLAVE;
  assign okPref   = forcePin ? okVec[1] : okVec[0];
  assign okAlt    = forcePin ? okVec[0] : okVec[1];

  always_comb begin
    unique case (selQ)
      GS_MASTER:  curOk = okVec[0];
      GS_SLAVE:   curOk = okVec[1];
      GS_STANDBY: curOk = okVec[2];
      default:    curOk = 1'b0;
    endcase
  end

  always_comb begin
    if (forceChg && okPref)   selNxt = prefGrp;
    else if (curOk)           selNxt = selQ;
    else if (okPref)          selNxt = prefGrp;
    else if (okAlt)           selNxt = altGrp;
    else if (okVec[2])        selNxt = GS_STANDBY;
    else                      selNxt = GS_NONE;
  end

  always_comb begin
    if (selQ != GS_NONE && settled) modeOut = MD_LOCKED;
    else if (everLocked)            modeOut = MD_HOLDOVER;
    else                            modeOut = MD_FREERUN;
  end

  assign strb.selValid = (selQ != GS_NONE);
  assign strb.restart  = (selQ == GS_NONE) && (selNxt != GS_NONE);

  always_ff @(posedge refClk) begin
    if (!rstN) begin
      selQ       <= GS_NONE;
      forceQ     <= 1'b0;
      everLocked <= 1'b0;
      swEvt      <= 1'b0;
    end else begin
      selQ   <= selNxt;
      forceQ <= forcePin;
      swEvt  <= (selNxt != selQ);
      if (modeOut == MD_LOCKED) everLocked <= 1'b1;
    end
  end

  p_strobe_marks_change_r11: assert property (@(posedge refClk) disable iff (!rstN)
    swEvt |-> selQ != $past(selQ));

  p_change_has_strobe_r11: assert property (@(posedge refClk) disable iff (!rstN)
    selQ != $past(selQ) |-> swEvt);

  p_master_healthy_r5: assert property (@(posedge refClk) disable iff (!rstN)
    selQ == GS_MASTER |-> !$past(failVec[0]));

  p_slave_healthy_r5: assert property (@(posedge refClk) disable iff (!rstN)
    selQ == GS_SLAVE |-> !$past(failVec[1]));

  p_standby_gate_r12: assert property (@(posedge refClk) disable iff (!rstN)
    selQ == GS_STANDBY |-> $past(standbyEn));

  p_lock_needs_input_r10: assert property (@(posedge refClk) disable iff (!rstN)
    modeOut == MD_LOCKED |-> selQ != GS_NONE);

endmodule

// File: rtl/prot_clk_sel.sv
module prot_clk_sel
  import pcs_pkg::*;
#(
  parameter int TIMEOUT    = 16,
  parameter int GOOD_EDGES = 4,
  parameter int SETTLE     = 8
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic [2:0] clkIn,
  input  logic       forcePin,
  input  logic       standbyEn,
  output logic [1:0] grpSel,
  output logic [1:0] opMode,
  output logic [2:0] alarm,
  output logic       swEvt
);
  ctrl_strb_t strb;
  logic [2:0] failVec;
  logic       settled;
  grp_e       selQ;
  mode_e      modeOut;

  pcs_datapath #(
    .NUM_IN(3), .TIMEOUT(TIMEOUT), .GOOD_EDGES(GOOD_EDGES), .SETTLE(SETTLE)
  ) dp_i (
    .refClk (refClk),
    .rstN   (rstN),
    .clkIn  (clkIn),
    .strb   (strb),
    .failVec(failVec),
    .settled(settled)
  );

  pcs_ctrl ctrl_i (
    .refClk   (refClk),
    .rstN     (rstN),
    .failVec  (failVec),
    .forcePin (forcePin),
    .standbyEn(standbyEn),
    .settled  (settled),
    .strb     (strb),
    .selQ     (selQ),
    .modeOut  (modeOut),
    .swEvt    (swEvt)
  );

  assign grpSel = selQ;
  assign opMode = modeOut;
  assign alarm  = failVec;

endmodule

// File: tb/prot_clk_sel_tb_top.sv
`timescale 1ns/1ps
module prot_clk_sel_tb_top;
  logic       refClk = 1'b0;
  logic       rstN;
  logic [2:0] clkIn;
  logic       forcePin, standbyEn;
  logic [1:0] grpSel, opMode;
  logic [2:0] alarm;
  logic       swEvt;

  logic [2:0] enIn = 3'b000;
  logic [1:0] phase = 2'd0;
  int checks = 0, errors = 0, evtCnt = 0, evtBase = 0;
  bit done = 0;

  always #5 refClk = ~refClk;

  prot_clk_sel #(.TIMEOUT(16), .GOOD_EDGES(4), .SETTLE(8)) dut_i (
    .refClk(refClk), .rstN(rstN), .clkIn(clkIn), .forcePin(forcePin),
    .standbyEn(standbyEn), .grpSel(grpSel), .opMode(opMode),
    .alarm(alarm), .swEvt(swEvt)
  );

  // input clocks: period 4 reference cycles, gated per input
  initial begin
    clkIn = 3'b000;
    forever begin
      @(negedge refClk);
      phase = phase + 2'd1;
      clkIn = enIn & {3{phase[1]}};
    end
  end

  // count strobe cycles
  initial forever begin
    @(negedge refClk);
    if (rstN && swEvt) evtCnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge refClk);
  endtask

  task automatic chkEvt(input string req, input int exp);
    chk(req, evtCnt - evtBase, exp);
    evtBase = evtCnt;
  endtask

  task automatic t_reset();
    rstN = 1'b0; forcePin = 1'b0; standbyEn = 1'b1;
    waitCyc(4);
    chk("R1 code in reset", grpSel, 3);
    chk("R1 mode in reset", opMode, 0);
    rstN = 1'b1;
    waitCyc(2);
    chk("R1 code after reset", grpSel, 3);
    chk("R1 mode after reset", opMode, 0);
    chk("R1 alarms after reset", alarm, 7);
  endtask

  task automatic t_bringUp();
    enIn = 3'b111;
    waitCyc(40);
    chk("R3 alarms cleared", alarm, 0);
    chk("R4 master preferred", grpSel, 0);
    chkEvt("R11 one strobe on first pick", 1);
    waitCyc(12);
    chk("R10 locked after settle", opMode, 1);
  endtask

  task automatic t_masterFail();
    enIn[0] = 1'b0;
    waitCyc(40);
    chk("R2 master alarm", alarm, 3'b001);
    chk("R5 fall back to slave", grpSel, 1);
    chk("R10 lock kept on switch", opMode, 1);
    chkEvt("R11 strobe on fallback", 1);
  endtask

  task automatic t_nonRevert();
    enIn[0] = 1'b1;
    waitCyc(40);
    chk("R3 master alarm cleared", alarm, 0);
    chk("R7 stays on slave", grpSel, 1);
    chkEvt("R7 no strobe", 0);
  endtask

  task automatic t_forceMoves();
    forcePin = 1'b1;
    waitCyc(4);
    chk("R4 force slave kept", grpSel, 1);
    forcePin = 1'b0;
    waitCyc(4);
    chk("R4 force master", grpSel, 0);
    forcePin = 1'b1;
    waitCyc(4);
    chk("R4 force slave", grpSel, 1);
    chkEvt("R11 two strobes", 2);
  endtask

  task automatic t_forceIgnored();
    enIn[0] = 1'b0;
    waitCyc(40);
    forcePin = 1'b0;
    waitCyc(4);
    chk("R6 force to failed master ignored", grpSel, 1);
    enIn[0] = 1'b1;
    waitCyc(40);
    chk("R7 kept slave after recovery", grpSel, 1);
    chkEvt("R6 no strobe", 0);
  endtask

  task automatic t_standby();
    enIn[1:0] = 2'b00;
    waitCyc(40);
    chk("R8 standby selected", grpSel, 2);
    chk("R8 alarms", alarm, 3'b011);
    chkEvt("R11 strobe to standby", 1);
  endtask

  task automatic t_holdover();
    standbyEn = 1'b0;
    waitCyc(4);
    chk("R12 standby dropped", grpSel, 3);
    chk("R9 holdover mode", opMode, 2);
    chkEvt("R11 strobe to none", 1);
  endtask

  task automatic t_partial();
    enIn[0] = 1'b1;
    waitCyc(7);
    enIn[0] = 1'b0;
    waitCyc(40);
    chk("R3 short burst keeps alarm", alarm[0], 1);
    chk("R9 still none", grpSel, 3);
  endtask

  task automatic t_recover();
    enIn[0] = 1'b1;
    waitCyc(30);
    chk("R4 master reselected", grpSel, 0);
    chkEvt("R11 strobe on recovery", 1);
    waitCyc(14);
    chk("R10 relocked", opMode, 1);
  endtask

  initial begin
    t_reset();
    t_bringUp();
    t_masterFail();
    t_nonRevert();
    t_forceMoves();
    t_forceIgnored();
    t_standby();
    t_holdover();
    t_partial();
    t_recover();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule